// File: doc/BRIEF.md
# Two-Wire Serial Slave with Word Register Bank

This block sits behind a two-wire serial bus as a slave and exposes a small bank of 16-bit registers to a bus master. The master selects the block with a 7-bit device address, sets an 8-bit word pointer, and then moves whole words. Each word travels as two bytes, most significant byte first. The pointer steps by one after every complete word, so a single transfer can stream through consecutive registers until the master ends it.

Reads are combined transfers. The master first writes the pointer, then issues a repeated START with the read bit set, and then clocks words out until it withholds the acknowledge on the last byte. Both bus lines are brought into the system clock domain and edge-detected there. The block pulls the data line low through an open-drain enable, and it reports every committed write word on a one-cycle strobe with its address and data. The lowest registers are read-only and hold fixed identification values. The remaining registers are writable and return to computed defaults on reset.

Top module: `twi_word_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sda_pull` and `wr_stb` are 0 until bus traffic occurs.
- R2: The slave answers only device address {0,1,1,ADDR_X,1,1,1}, which is 0x37 with the default ADDR_X=0. For any other address it gives no acknowledge and keeps SDA released until the next START.
- R3: A write consists of the device address byte with R/W=0, the pointer byte, and then data bytes sent high byte then low byte. A word is committed only when its low byte has been acknowledged. On commit, `wr_stb` pulses for exactly one cycle with `wr_addr` set to the pointer and `wr_data` set to {high,low}.
- R4: The pointer advances by one after each committed or transmitted word, never after a single byte. Burst writes and burst reads therefore cover consecutive registers.
- R5: If a STOP arrives after only the high byte of a word, that partial word is discarded. No strobe is produced and the register is left unchanged.
- R6: A read returns the high byte then the low byte of register n, then of n+1, and so on. It continues while the master acknowledges. After the master NACKs, SDA stays released.
- R7: Registers 0 and 1 are read-only and ignore writes. Pointer values at or above the register count read as 0x0000.
- R8: The slave pulls SDA low during the ninth clock that follows each device address byte that matches, each pointer byte, and each write data byte. It changes SDA only while SCL is low.
- R9: A START seen in the middle of a byte restarts bit counting. A complete transfer that follows it works normally.
- R10: After reset, register i reads 16'hA03C | (i << 8). For example, register 2 reads 0xA23C and register 6 reads 0xA63C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle strobe for a committed write word |
| wr_addr | output | 8 | Register address of the committed word |
| wr_data | output | 16 | Data of the committed word |

## Verification
The hardest situation to reach from the ports is a START that lands partway through a byte. A conforming master never produces it. The bench therefore drives SCL and SDA by hand: it clocks four address bits, raises SDA while SCL is low, lifts SCL, and drops SDA. A stale bit count would misalign the next address byte and remove the acknowledge. A second hard case is the partial word, a STOP after one data byte. This is reached the same way, and the bench then reads the register back through a combined transfer to show that it did not change.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_e;

  // Reset value of register idx: fixed pattern with the index in bits 11:8
  function automatic logic [15:0] word_default(input int unsigned idx);
    logic [3:0] nib;
    nib = idx[3:0];
    return 16'hA03C | {4'h0, nib, 8'h00};
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [2:0] scl_p;
  logic [2:0] sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  assign scl_lvl   = scl_p[1];
  assign sda_lvl   = sda_p[1];
  assign scl_rise  = scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] & scl_p[2];
  assign start_det = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  assign stop_det  = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
  import twi_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int NUM_RO = 2,
  parameter int AW     = 8,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DW-1:0] words [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_word
    if (i < NUM_RO) begin : g_ro
      assign words[i] = DW'(word_default(i));
    end else begin : g_rw
      logic [DW-1:0] q;
      logic          we;
      assign we = wr_en && (wr_addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= DW'(word_default(i));
        end else if (we) begin
          q <= wr_data;
        end
      end
      assign words[i] = q;
    end
  end

  always_comb begin
    if (rd_addr < AW'(NREGS)) begin
      rd_data = words[rd_addr[IW-1:0]];
    end else begin
      rd_data = '0;
    end
  end

endmodule

// File: rtl/twi_proto.sv
module twi_proto
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h37
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        sda_lvl,
  input  logic [15:0] rd_data,
  output logic [7:0]  ptr,
  output logic        sda_pull,
  output logic        wr_stb,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        idle
);

  twi_state_e  state_q, state_d;
  logic [2:0]  cnt_q, cnt_d;
  logic        done_q, done_d;
  logic [7:0]  sh_q, sh_d;
  logic [7:0]  tx_q, tx_d;
  logic [15:0] word_q, word_d;
  logic [7:0]  hi_q, hi_d;
  logic        lo_q, lo_d;
  logic        rdm_q, rdm_d;
  logic [7:0]  ptr_q, ptr_d;
  logic        pull_q, pull_d;
  logic        stb_q, stb_d;
  logic [7:0]  waddr_q, waddr_d;
  logic [15:0] wdata_q, wdata_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    word_d  = word_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    rdm_d   = rdm_q;
    ptr_d   = ptr_q;
    pull_d  = pull_q;
    stb_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;

    if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      done_d  = 1'b0;
      pull_d  = 1'b0;
      lo_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
      pull_d  = 1'b0;
      lo_d    = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            if (state_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                pull_d  = 1'b1;
                rdm_d   = sh_q[0];
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_REG) begin
              pull_d  = 1'b1;
              state_d = ST_REG_ACK;
            end else begin
              pull_d  = 1'b1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rdm_q) begin
              word_d  = rd_data;
              tx_d    = rd_data[15:8];
              pull_d  = ~rd_data[15];
              lo_d    = 1'b0;
              state_d = ST_RD;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_REG;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            ptr_d   = sh_q;
            lo_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR;
            if (!lo_q) begin
              hi_d = sh_q;
              lo_d = 1'b1;
            end else begin
              stb_d   = 1'b1;
              waddr_d = ptr_q;
              wdata_d = {hi_q, sh_q};
              ptr_d   = ptr_q + 8'd1;
              lo_d    = 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) done_d = 1'b1;
          end else if (scl_fall) begin
            if (done_q) begin
              done_d  = 1'b0;
              pull_d  = 1'b0;
              state_d = ST_RD_ACK;
              if (lo_q) ptr_d = ptr_q + 8'd1;
            end else begin
              tx_d   = {tx_q[6:0], 1'b0};
              pull_d = ~tx_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (sda_lvl) state_d = ST_IDLE;
          end else if (scl_fall) begin
            cnt_d   = '0;
            state_d = ST_RD;
            if (!lo_q) begin
              lo_d   = 1'b1;
              tx_d   = word_q[7:0];
              pull_d = ~word_q[7];
            end else begin
              lo_d   = 1'b0;
              word_d = rd_data;
              tx_d   = rd_data[15:8];
              pull_d = ~rd_data[15];
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      word_q  <= '0;
      hi_q    <= '0;
      lo_q    <= 1'b0;
      rdm_q   <= 1'b0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      stb_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      word_q  <= word_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      rdm_q   <= rdm_d;
      ptr_q   <= ptr_d;
      pull_q  <= pull_d;
      stb_q   <= stb_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign ptr      = ptr_q;
  assign sda_pull = pull_q;
  assign wr_stb   = stb_q;
  assign wr_addr  = waddr_q;
  assign wr_data  = wdata_q;
  assign idle     = (state_q == ST_IDLE);

endmodule

// File: rtl/twi_word_slave.sv
module twi_word_slave #(
  parameter int   NREGS  = 8,
  parameter int   NUM_RO = 2,
  parameter logic ADDR_X = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  output logic        wr_stb,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data
);

  localparam logic [6:0] DEV_ADDR = {3'b011, ADDR_X, 3'b111};

  logic [1:0]  rst_pipe;
  logic        rst_int_n;
  logic        scl_lvl;
  logic        sda_lvl;
  logic        scl_rise;
  logic        scl_fall;
  logic        start_det;
  logic        stop_det;
  logic [7:0]  ptr;
  logic [15:0] rd_data;
  logic        idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  twi_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .sda_pull  (sda_pull),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .idle      (idle)
  );

  twi_regbank #(.NREGS(NREGS), .NUM_RO(NUM_RO), .AW(8), .DW(16)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/twi_word_slave_chk.sv
module twi_word_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_pull,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic [7:0] ptr,
  input logic       idle
);

  // R3
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R4
  ptr_steps_per_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ptr == wr_addr + 8'd1));

  // R8
  sda_moves_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_lvl);

  // R2
  released_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);

endmodule

bind twi_word_slave twi_word_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .sda_pull (sda_pull),
  .wr_stb   (wr_stb),
  .wr_addr  (wr_addr),
  .ptr      (ptr),
  .idle     (idle)
);

// File: tb/test_twi_word_slave.sv
module test_twi_word_slave;

  localparam int H = 10;

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        sda_line;
  logic        sda_pull;
  logic        wr_stb;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [23:0] wr_q [$];
  logic [15:0] rd_q [$];

  assign sda_line = sda_m & ~sda_pull;

  twi_word_slave i_twi_word_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .sda_pull (sda_pull),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input int i);
    return 16'hA03C | (16'(i) << 8);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor for committed writes
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (wr_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected write strobe", {8'h0, wr_addr, wr_data}, 32'h0);
      end else begin
        logic [23:0] e;
        e = wr_q.pop_front();
        chk({wr_addr, wr_data} == e, "R3", "write strobe addr/data",
            {8'h0, wr_addr, wr_data}, {8'h0, e});
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b0; cyc(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    cyc(H/2); sda_m = 1'b1; cyc(H/2);
    scl_m = 1'b1; cyc(H);
    bus_start();
  endtask

  task automatic bus_stop();
    cyc(H/2); sda_m = 1'b0; cyc(H/2);
    scl_m = 1'b1; cyc(H);
    sda_m = 1'b1; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      cyc(H/2); sda_m = b[i]; cyc(H/2);
      scl_m = 1'b1; cyc(H);
      scl_m = 1'b0;
    end
    cyc(H/2); sda_m = 1'b1; cyc(H/2);
    scl_m = 1'b1; cyc(H/2);
    acked = ~sda_line;
    cyc(H/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      cyc(H/2); sda_m = 1'b1; cyc(H/2);
      scl_m = 1'b1; cyc(H/2);
      b = {b[6:0], sda_line};
      cyc(H/2);
      scl_m = 1'b0;
    end
    cyc(H/2); sda_m = give_ack ? 1'b0 : 1'b1; cyc(H/2);
    scl_m = 1'b1; cyc(H);
    scl_m = 1'b0;
    cyc(H/2); sda_m = 1'b1;
  endtask

  // driver: write n words (up to 3) starting at pointer p
  task automatic wr_words(input logic [7:0] p, input int n,
                          input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] w2);
    bit a;
    logic [15:0] w [3];
    w[0] = w0; w[1] = w1; w[2] = w2;
    bus_start();
    send_byte(8'h6E, a); chk(a, "R8", "ack on device address", 32'(a), 1);
    send_byte(p, a);     chk(a, "R8", "ack on pointer byte", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      wr_q.push_back({8'(p + 8'(k)), w[k]});
      send_byte(w[k][15:8], a); chk(a, "R8", "ack on data high byte", 32'(a), 1);
      send_byte(w[k][7:0], a);  chk(a, "R8", "ack on data low byte", 32'(a), 1);
    end
    bus_stop();
    cyc(4);
  endtask

  // driver pushes expected words, then reads n words from p and compares
  task automatic rd_words(input logic [7:0] p, input int n, input string req);
    bit a;
    logic [7:0] hb, lb;
    logic [15:0] e;
    bus_start();
    send_byte(8'h6E, a); chk(a, "R8", "ack on device address (read setup)", 32'(a), 1);
    send_byte(p, a);     chk(a, "R8", "ack on pointer byte (read setup)", 32'(a), 1);
    bus_rstart();
    send_byte(8'h6F, a); chk(a, "R6", "ack on read address", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(1'b1, hb);
      recv_byte(k != n - 1, lb);
      e = rd_q.pop_front();
      chk({hb, lb} == e, req, $sformatf("read word at 0x%02h", 8'(p + 8'(k))),
          {16'h0, hb, lb}, {16'h0, e});
    end
    cyc(H);
    chk(sda_pull == 1'b0, "R6", "SDA released after NACK", 32'(sda_pull), 0);
    bus_stop();
    cyc(4);
  endtask

  initial begin
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    cyc(3);
    chk(sda_pull == 1'b0, "R1", "sda_pull in reset", 32'(sda_pull), 0);
    chk(wr_stb == 1'b0, "R1", "wr_stb in reset", 32'(wr_stb), 0);
    rst_n = 1'b1;
    cyc(10);
    chk(sda_pull == 1'b0, "R1", "sda_pull after reset", 32'(sda_pull), 0);
    chk(wr_stb == 1'b0, "R1", "wr_stb after reset", 32'(wr_stb), 0);

    // R10 defaults, R7 read-only identity values
    for (int i = 0; i < 8; i++) rd_q.push_back(dflt(i));
    rd_words(8'h00, 8, "R10");

    // R3 single word write
    wr_words(8'h02, 1, 16'h1234, 16'h0, 16'h0);
    // R4 burst write
    wr_words(8'h03, 3, 16'hBEEF, 16'h0F0F, 16'h5555);
    // R7 write to read-only register
    wr_words(8'h00, 1, 16'hFFFF, 16'h0, 16'h0);
    rd_q.push_back(dflt(0));
    rd_words(8'h00, 1, "R7");

    // R5 partial word then STOP
    begin
      bit a;
      bus_start();
      send_byte(8'h6E, a); chk(a, "R5", "ack on device address", 32'(a), 1);
      send_byte(8'h06, a); chk(a, "R5", "ack on pointer", 32'(a), 1);
      send_byte(8'h99, a); chk(a, "R5", "ack on lone high byte", 32'(a), 1);
      bus_stop();
      cyc(4);
    end

    // R2 non-matching address
    begin
      bit a;
      bus_start();
      send_byte(8'h7E, a); chk(!a, "R2", "no ack on foreign address", 32'(a), 0);
      send_byte(8'h07, a); chk(!a, "R2", "SDA stays released after foreign address", 32'(a), 0);
      bus_stop();
      cyc(4);
    end

    // R9 START in the middle of an address byte
    begin
      bit a;
      logic [3:0] part;
      part = 4'b0110;
      bus_start();
      for (int i = 3; i >= 0; i--) begin
        cyc(H/2); sda_m = part[i]; cyc(H/2);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0;
      end
      cyc(H/2); sda_m = 1'b1; cyc(H/2);
      scl_m = 1'b1; cyc(H);
      bus_start();
      wr_q.push_back({8'h07, 16'hA5A5});
      send_byte(8'h6E, a); chk(a, "R9", "ack after mid-byte START", 32'(a), 1);
      send_byte(8'h07, a); chk(a, "R9", "ack on pointer", 32'(a), 1);
      send_byte(8'hA5, a); chk(a, "R9", "ack on high byte", 32'(a), 1);
      send_byte(8'hA5, a); chk(a, "R9", "ack on low byte", 32'(a), 1);
      bus_stop();
      cyc(4);
    end

    // R6 / R4 burst read back of written values, R5 untouched register 6
    rd_q.push_back(16'h1234);
    rd_q.push_back(16'hBEEF);
    rd_q.push_back(16'h0F0F);
    rd_q.push_back(16'h5555);
    rd_q.push_back(dflt(6));
    rd_q.push_back(16'hA5A5);
    rd_words(8'h02, 6, "R6");

    // R7 out-of-range pointer reads zero
    rd_q.push_back(16'h0000);
    rd_q.push_back(16'h0000);
    rd_words(8'h20, 2, "R7");

    chk(wr_q.size() == 0, "R3", "all expected writes committed", 32'(wr_q.size()), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule